// File: doc/BRIEF.md
# Fiber Fast Ethernet 5-bit Symbol Datapath with NRZI Line Coding

This block is the clocked core of a fiber 100 Mb/s physical layer that talks to the layer above through 5-bit code groups. Everything runs on one bit-rate clock. On the transmit side, a divide-by-SYM_W phase counter produces the symbol clock. One code group is taken in per symbol period and sent out least-significant bit first, one bit per clock. The serial stream is then NRZI-coded: the line level flips for a 1 and holds for a 0.

On the receive side, each line sample qualified by a bit enable is compared with the previous qualified sample. A difference decodes as a 1 and no difference as a 0. Five decoded bits are packed least-significant first into a received code group, which is presented with a receive symbol clock whose falling edge marks each update.

An active-low loopback input feeds the transmit line level into the decoder, in place of the line input, at full bit rate. An active-low power-down input holds every register in its reset state. A signal-detect output follows a raw line-activity input, but it changes only after that input has disagreed with it for DET_CYCLES clocks in a row.

Top module: `fx_symbol_serdes`

## Requirements
- R1: While running, `tx_sym_ck` is high for 3 clocks and low for 2 clocks, repeating. The code group on `tx_symbol` is sampled at the clock edge on which `tx_sym_ck` rises. After reset or power-down exit, the first such edge is the 4th clock edge.
- R2: A code group captured at edge E is sent bit 0 first. For k = 0..4, `tx_line` after edge E+1+k equals its previous value XOR bit k: a 1 toggles the line and a 0 holds it.
- R3: In normal mode, the decoder samples `rx_line` only on edges where `rx_bit_en` is 1. Each sample yields bit = sample XOR previous sample, and the previous sample starts at 0. Edges with `rx_bit_en` low are ignored.
- R4: Decoded bits fill `rx_symbol` from bit 0 upward. The first five qualified samples after reset form the first code group. `rx_symbol` is updated on the same edge on which `rx_sym_ck` falls, and at no other time.
- R5: With `lpbk_n` = 0, the decoder takes `tx_line` on every clock, and `rx_line` and `rx_bit_en` have no effect. Started from reset, the received sequence is one all-zero group followed by every transmitted group in order.
- R6: `sig_det` rises on the DET_CYCLES-th consecutive edge at which `sd_raw` is 1. A high pulse of DET_CYCLES-1 clocks leaves it low.
- R7: `sig_det` falls on the DET_CYCLES-th consecutive edge at which `sd_raw` is 0.
- R8: While `pd_n` = 0, from the edge after it is sampled low, the outputs hold their reset values: `tx_line` 0, `rx_symbol` 0, `sig_det` 0, `tx_sym_ck` 1, `rx_sym_ck` 1. This holds whatever `sd_raw`, `rx_line` or `tx_symbol` do.
- R9: After `pd_n` returns high, the block behaves exactly as after a reset: the R1 and R5 timing holds from that edge.
- R10: During reset, the outputs take the values listed in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down; low holds all state cleared |
| lpbk_n | input | 1 | Active-low loopback select |
| tx_symbol | input | SYM_W | Transmit code group |
| tx_sym_ck | output | 1 | Transmit symbol clock; rising edge samples `tx_symbol` |
| tx_line | output | 1 | NRZI-coded transmit line level |
| rx_line | input | 1 | NRZI receive line level |
| rx_bit_en | input | 1 | Qualifies `rx_line` samples in normal mode |
| rx_symbol | output | SYM_W | Received code group |
| rx_sym_ck | output | 1 | Receive symbol clock; falls when `rx_symbol` updates |
| sd_raw | input | 1 | Unfiltered line-activity indication |
| sig_det | output | 1 | Time-qualified signal detect |

## Verification
The transmit path is driven with all-zero and all-one groups, alternating bit patterns and a counting sequence. A wrong bit order, an inverted line code or a missing toggle on a 1 therefore each show up as a distinct mismatch. The receive path is fed the same kinds of groups with idle gaps of varying length between qualified bits, so decoding unqualified samples would corrupt the groups. Loopback is run with a toggling `rx_line` and a low `rx_bit_en`, which separates a correctly routed decoder input from a leaking line input. Signal detect is driven with a pulse one clock short of the threshold and with exact-length runs in both directions.

// File: rtl/fx_serdes_pkg.sv
package fx_serdes_pkg;

   localparam int unsigned DEF_SYM_W      = 5;
   localparam int unsigned DEF_DET_CYCLES = 625;

   typedef enum logic {
      DET_QUIET  = 1'b0,
      DET_ACTIVE = 1'b1
   } det_state_e;

   // one NRZI step: a 1 flips the level, a 0 keeps it
   function automatic logic nrzi_step(input logic level, input logic data_bit);
      return level ^ data_bit;
   endfunction

   // inverse: a change between consecutive samples is a 1
   function automatic logic nrzi_undo(input logic prev_level, input logic cur_level);
      return prev_level ^ cur_level;
   endfunction

endpackage

// File: rtl/fx_tx_serializer.sv
module fx_tx_serializer
   import fx_serdes_pkg::*;
#(
   parameter int unsigned SYM_W = DEF_SYM_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [SYM_W-1:0] sym_in,
   output logic             sym_ck,
   output logic             line_out
);

   localparam int unsigned PH_W    = (SYM_W > 2) ? $clog2(SYM_W) : 1;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(SYM_W - 1);
   localparam logic [PH_W-1:0] PH_HIGH = PH_W'((SYM_W - 1) / 2);
   // start one phase in so that the loopback round trip lands on a group boundary
   localparam logic [PH_W-1:0] PH_INIT = PH_W'(1);

   logic [PH_W-1:0]  phase_q;
   logic [SYM_W-1:0] shift_q;
   logic             level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_INIT;
         shift_q <= '0;
         level_q <= 1'b0;
      end else if (clr) begin
         phase_q <= PH_INIT;
         shift_q <= '0;
         level_q <= 1'b0;
      end else begin
         phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
         if (phase_q == PH_LAST) begin
            shift_q <= sym_in;
         end else begin
            shift_q <= shift_q >> 1;
         end
         level_q <= nrzi_step(level_q, shift_q[0]);
      end
   end

   assign sym_ck   = (phase_q <= PH_HIGH);
   assign line_out = level_q;

endmodule

// File: rtl/fx_rx_deserializer.sv
module fx_rx_deserializer
   import fx_serdes_pkg::*;
#(
   parameter int unsigned SYM_W = DEF_SYM_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             bit_en,
   input  logic             line_in,
   output logic [SYM_W-1:0] sym_out,
   output logic             sym_ck
);

   localparam int unsigned CNT_W    = (SYM_W > 2) ? $clog2(SYM_W) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYM_W - 1);
   localparam logic [CNT_W-1:0] CNT_RISE = CNT_W'((SYM_W - 1) / 2);

   logic             prev_q;
   logic [SYM_W-1:0] acc_q;
   logic [CNT_W-1:0] cnt_q;
   logic [SYM_W-1:0] sym_q;
   logic             ck_q;
   logic             dec_bit;
   logic [SYM_W-1:0] acc_next;

   assign dec_bit  = nrzi_undo(prev_q, line_in);
   assign acc_next = {dec_bit, acc_q[SYM_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         acc_q  <= '0;
         cnt_q  <= '0;
         sym_q  <= '0;
         ck_q   <= 1'b1;
      end else if (clr) begin
         prev_q <= 1'b0;
         acc_q  <= '0;
         cnt_q  <= '0;
         sym_q  <= '0;
         ck_q   <= 1'b1;
      end else if (bit_en) begin
         prev_q <= line_in;
         acc_q  <= acc_next;
         if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            sym_q <= acc_next;
            ck_q  <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_RISE) begin
               ck_q <= 1'b1;
            end
         end
      end
   end

   assign sym_out = sym_q;
   assign sym_ck  = ck_q;

endmodule

// File: rtl/fx_sig_qualifier.sv
module fx_sig_qualifier
   import fx_serdes_pkg::*;
#(
   parameter int unsigned DET_CYCLES = DEF_DET_CYCLES
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic raw_in,
   output logic det_out
);

   localparam int unsigned DW = $clog2(DET_CYCLES + 1);
   localparam logic [DW-1:0] RUN_LAST = DW'(DET_CYCLES - 1);

   det_state_e    state_q;
   logic [DW-1:0] run_q;
   logic          differs;

   assign differs = (raw_in != state_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= DET_QUIET;
         run_q   <= '0;
      end else if (clr) begin
         state_q <= DET_QUIET;
         run_q   <= '0;
      end else if (!differs) begin
         run_q <= '0;
      end else if (run_q == RUN_LAST) begin
         state_q <= raw_in ? DET_ACTIVE : DET_QUIET;
         run_q   <= '0;
      end else begin
         run_q <= run_q + 1'b1;
      end
   end

   assign det_out = (state_q == DET_ACTIVE);

endmodule

// File: rtl/fx_symbol_serdes.sv
module fx_symbol_serdes
   import fx_serdes_pkg::*;
#(
   parameter int unsigned SYM_W      = DEF_SYM_W,
   parameter int unsigned DET_CYCLES = DEF_DET_CYCLES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pd_n,
   input  logic             lpbk_n,
   input  logic [SYM_W-1:0] tx_symbol,
   output logic             tx_sym_ck,
   output logic             tx_line,
   input  logic             rx_line,
   input  logic             rx_bit_en,
   output logic [SYM_W-1:0] rx_symbol,
   output logic             rx_sym_ck,
   input  logic             sd_raw,
   output logic             sig_det
);

   generate
      if (SYM_W < 2) begin : g_bad_width
         $error("fx_symbol_serdes: SYM_W must be at least 2");
      end
      if (DET_CYCLES < 2) begin : g_bad_det
         $error("fx_symbol_serdes: DET_CYCLES must be at least 2");
      end
   endgenerate

   logic clr;
   logic dec_line;
   logic dec_en;

   assign clr = !pd_n;

   fx_tx_serializer #(.SYM_W(SYM_W)) ser_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .sym_in   (tx_symbol),
      .sym_ck   (tx_sym_ck),
      .line_out (tx_line)
   );

   // loopback: decoder follows the transmit level at full bit rate
   assign dec_line = lpbk_n ? rx_line   : tx_line;
   assign dec_en   = lpbk_n ? rx_bit_en : 1'b1;

   fx_rx_deserializer #(.SYM_W(SYM_W)) des_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .bit_en  (dec_en),
      .line_in (dec_line),
      .sym_out (rx_symbol),
      .sym_ck  (rx_sym_ck)
   );

   fx_sig_qualifier #(.DET_CYCLES(DET_CYCLES)) sdq_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .raw_in  (sd_raw),
      .det_out (sig_det)
   );

endmodule

// File: rtl/fx_symbol_serdes_chk.sv
module fx_symbol_serdes_chk #(
   parameter int unsigned SYM_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pd_n,
   input logic             sd_raw,
   input logic             sig_det,
   input logic             tx_sym_ck,
   input logic             tx_line,
   input logic [SYM_W-1:0] rx_symbol,
   input logic             rx_sym_ck
);

   // R1: symbol clock stays high the cycle after it rises
   assert_ck_high_R1: assert property (@(posedge clk) disable iff (!rst_n || !pd_n)
      $rose(tx_sym_ck) |=> tx_sym_ck);

   // R1: symbol clock stays low the cycle after it falls
   assert_ck_low_R1: assert property (@(posedge clk) disable iff (!rst_n || !pd_n)
      $fell(tx_sym_ck) |=> !tx_sym_ck);

   // R4: received group only moves together with a falling receive clock
   assert_rx_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_n && $past(pd_n) && !$stable(rx_symbol)) |-> $fell(rx_sym_ck));

   // R6 / R7: detect output only moves toward the level the raw input held
   assert_det_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_n && $past(pd_n) && !$stable(sig_det)) |-> (sig_det == $past(sd_raw)));

   // R8: power-down holds outputs at their cleared values
   assert_pd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !pd_n |=> (!tx_line && !sig_det && rx_symbol == '0 && tx_sym_ck && rx_sym_ck));

endmodule

bind fx_symbol_serdes fx_symbol_serdes_chk #(.SYM_W(SYM_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .pd_n      (pd_n),
   .sd_raw    (sd_raw),
   .sig_det   (sig_det),
   .tx_sym_ck (tx_sym_ck),
   .tx_line   (tx_line),
   .rx_symbol (rx_symbol),
   .rx_sym_ck (rx_sym_ck)
);

// File: tb/fx_symbol_serdes_tb_top.sv
`timescale 1ns/1ps
module fx_symbol_serdes_tb_top;

   localparam int W   = 5;
   localparam int DET = 625;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         pd_n = 1'b1;
   logic         lpbk_n = 1'b1;
   logic [W-1:0] tx_symbol = '0;
   logic         tx_sym_ck;
   logic         tx_line;
   logic         rx_line = 1'b0;
   logic         rx_bit_en = 1'b0;
   logic [W-1:0] rx_symbol;
   logic         rx_sym_ck;
   logic         sd_raw = 1'b0;
   logic         sig_det;

   int n_cmp = 0;
   int n_bad = 0;

   logic [W-1:0] tq[$];
   logic [W-1:0] rq[$];
   logic         mon_en = 1'b0;
   logic         push_rx = 1'b0;

   always #2 clk = ~clk;

   fx_symbol_serdes #(.SYM_W(W), .DET_CYCLES(DET)) dut_i (
      .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .lpbk_n(lpbk_n),
      .tx_symbol(tx_symbol), .tx_sym_ck(tx_sym_ck), .tx_line(tx_line),
      .rx_line(rx_line), .rx_bit_en(rx_bit_en), .rx_symbol(rx_symbol),
      .rx_sym_ck(rx_sym_ck), .sd_raw(sd_raw), .sig_det(sig_det)
   );

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [W-1:0] pat(input int i);
      case (i % 6)
         0: return 5'h00;
         1: return 5'h1F;
         2: return 5'h15;
         3: return 5'h0A;
         4: return 5'h01;
         default: return W'(i * 7 + 3);
      endcase
   endfunction

   // monitor: decodes tx line itself and compares received groups
   logic         t_prev_line, t_prev_ck, t_coll, r_prev_ck;
   int           t_idx;
   logic [W-1:0] t_acc;
   always @(negedge clk) begin
      if (!mon_en) begin
         t_prev_line = 1'b0; t_prev_ck = 1'b1; t_coll = 1'b0; t_idx = 0;
         r_prev_ck = 1'b1; t_acc = '0;
      end else begin
         logic b;
         b = tx_line ^ t_prev_line;
         t_prev_line = tx_line;
         if (t_coll) begin
            t_acc[t_idx] = b;
            t_idx++;
            if (t_idx == W) begin
               t_coll = 1'b0;
               if (tq.size() > 0) begin
                  logic [W-1:0] e;
                  e = tq.pop_front();
                  chk(t_acc == e, "R2 tx serial NRZI group", t_acc, e);
               end
            end
         end
         if (tx_sym_ck && !t_prev_ck) begin
            t_coll = 1'b1; t_idx = 0;
         end
         t_prev_ck = tx_sym_ck;
         if (!rx_sym_ck && r_prev_ck && rq.size() > 0) begin
            logic [W-1:0] e;
            e = rq.pop_front();
            chk(rx_symbol == e, lpbk_n ? "R3 R4 rx group" : "R5 loopback group", rx_symbol, e);
         end
         r_prev_ck = rx_sym_ck;
      end
   end

   task automatic drive_tx(input int n, input int base);
      tx_symbol = pat(base);
      tq.push_back(pat(base));
      if (push_rx) rq.push_back(pat(base));
      for (int i = 1; i < n; i++) begin
         @(posedge tx_sym_ck);
         @(negedge clk);
         tx_symbol = pat(base + i);
         tq.push_back(pat(base + i));
         if (push_rx) rq.push_back(pat(base + i));
      end
   endtask

   task automatic drive_rx(input int n);
      logic lvl;
      lvl = 1'b0;
      for (int i = 0; i < n; i++) begin
         logic [W-1:0] s;
         s = pat(i + 2);
         rq.push_back(s);
         for (int b = 0; b < W; b++) begin
            lvl = lvl ^ s[b];
            rx_line = lvl;
            rx_bit_en = 1'b1;
            @(negedge clk);
            rx_bit_en = 1'b0;
            rx_line = ~rx_line;   // unqualified garbage between samples
            repeat ((i + b) % 3) @(negedge clk);
            rx_line = lvl;
         end
      end
      rx_bit_en = 1'b0;
   endtask

   task automatic reset_outputs_check(input string tag);
      chk(tx_line == 1'b0, tag, tx_line, 0);
      chk(rx_symbol == '0, tag, rx_symbol, 0);
      chk(sig_det == 1'b0, tag, sig_det, 0);
      chk(tx_sym_ck == 1'b1 && rx_sym_ck == 1'b1, tag, {tx_sym_ck, rx_sym_ck}, 3);
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      tx_symbol = pat(0);
      repeat (3) @(negedge clk);
      reset_outputs_check("R10 reset values");
      tq.delete(); rq.delete();
      mon_en = 1'b1;
      // phase A: normal mode, independent tx and rx traffic
      fork
         drive_tx(14, 0);
         begin @(negedge clk); rst_n = 1'b1; end
      join_none
      @(negedge clk); @(negedge clk);
      // R1: first capture on 4th edge after reset
      chk(tx_sym_ck == 1'b1, "R1 ck high after edges 1..", tx_sym_ck, 1);
      fork
         drive_rx(14);
      join
      wait fork;
      repeat (20) @(negedge clk);
      chk(tq.size() == 0, "R1 R2 all tx groups seen", tq.size(), 0);
      chk(rq.size() == 0, "R3 R4 all rx groups seen", rq.size(), 0);

      // signal detect: short pulse then exact runs
      sd_raw = 1'b1;
      repeat (DET - 1) @(negedge clk);
      sd_raw = 1'b0;
      repeat (DET + 5) @(negedge clk);
      chk(sig_det == 1'b0, "R6 short pulse ignored", sig_det, 0);
      sd_raw = 1'b1;
      repeat (DET - 1) @(negedge clk);
      chk(sig_det == 1'b0, "R6 not yet high", sig_det, 0);
      @(negedge clk);
      chk(sig_det == 1'b1, "R6 rises at threshold", sig_det, 1);
      sd_raw = 1'b0;
      repeat (DET - 1) @(negedge clk);
      chk(sig_det == 1'b1, "R7 not yet low", sig_det, 1);
      @(negedge clk);
      chk(sig_det == 1'b0, "R7 falls at threshold", sig_det, 0);

      // power-down with activity on all inputs
      mon_en = 1'b0;
      sd_raw = 1'b1;
      pd_n = 1'b0;
      @(negedge clk);
      for (int c = 0; c < 700; c++) begin
         rx_line = c[0];
         rx_bit_en = c[1];
         tx_symbol = W'(c);
         @(negedge clk);
         if (c % 100 == 0) reset_outputs_check("R8 power-down quiet");
      end
      reset_outputs_check("R8 power-down after long activity");

      // leave power-down into loopback: behaves like reset
      lpbk_n = 1'b0;
      rx_bit_en = 1'b0;
      sd_raw = 1'b0;
      tq.delete(); rq.delete();
      rq.push_back('0);
      push_rx = 1'b1;
      tx_symbol = pat(3);
      @(negedge clk);
      mon_en = 1'b1;
      fork
         drive_tx(12, 3);
         begin
            pd_n = 1'b1;
            for (int c = 0; c < 90; c++) begin
               rx_line = ~rx_line;
               @(negedge clk);
            end
         end
      join
      repeat (20) @(negedge clk);
      chk(tq.size() == 0, "R9 tx groups after pd exit", tq.size(), 0);
      chk(rq.size() == 0, "R5 loopback groups all seen", rq.size(), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule